// File: doc/BRIEF.md
# TLB Maintenance Command Controller

This block holds the control register through which software maintains two small fully associative translation buffers: one serving instruction fetches and one serving data accesses. Each buffer has a fixed number of entries (a power of two, eight by default). Every entry carries a valid flag, a lock flag, an address-space identifier, a virtual tag and a physical page. Writing the 32-bit control register can invalidate every entry, invalidate the unlocked entries, invalidate the unlocked entries of the current address space, or probe a buffer with a tag held in a separate address register.

The register also exposes a read-only allocation-address field. This field tells maintenance software which entry to use next: the entry that a probe matched, the entry the round-robin replacement pointer picks, or the entry a data-side access fault reported. Every command takes effect on the clock edge that samples the register write, and its result is readable from the next cycle on.

A side port loads entries. Each load moves the replacement pointer of the buffer it writes to the entry just after the loaded one. Probes and allocation queries leave that pointer where it is.

Top module: `tlb_op_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `probe_hit` and `probe_ppage` are 0, and every entry of both buffers is invalid.
- R2: Read layout: bits 31:16 hold the allocation address, which is the entry index in the low bits with zeros above. Bit 4 is the buffer select. Bits 3:1 are an access-type field that is stored and read back but has no effect. Bits 15:5 and bit 0 always read 0. Writes to bits 31:16 are ignored.
- R3: A probe is a write with bit 8 set. It hits when an entry of the selected buffer is valid, has a tag equal to `srch_vtag` and has an identifier equal to `cur_asid`. On a hit, the allocation address becomes the lowest matching index, `probe_hit` becomes 1 and `probe_ppage` becomes that entry's page.
- R4: A probe that misses loads the allocation address with the replacement victim of the selected buffer, and sets `probe_hit` and `probe_ppage` to 0.
- R5: The victim is the first index, counting up from the buffer's replacement pointer and wrapping, that is not both valid and locked. If every entry is valid and locked, the victim is the pointer itself. A load to index i sets that buffer's pointer to i+1, with wrap-around. Probes and allocation queries do not move the pointer.
- R6: A write with bit 0 set loads the allocation address with the victim of the selected buffer.
- R7: A pulse on `derr_en` loads the allocation address with `derr_idx`, unless a register command loads the allocation address in the same cycle.
- R8: A write with bit 7 set invalidates every entry of both buffers, locked or not. It also clears the lock flags and resets both replacement pointers to 0.
- R9: A write with bit 6 set invalidates, in both buffers, every entry whose lock flag is 0.
- R10: A write with bit 5 set invalidates, in both buffers, every unlocked entry whose identifier equals `cur_asid`. All other entries are left unchanged.
- R11: Bit 4 set to 1 steers probes and allocation queries to the instruction buffer; 0 steers them to the data buffer.
- R12: When several command bits are written together, only the highest of this order acts: bit 7, bit 6, bit 5, bit 8, bit 0. The others are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data |
| srch_vtag | input | VTAG_W | Tag from the address register, used by probes |
| cur_asid | input | ASID_W | Current address-space identifier |
| ld_en | input | 1 | Entry load strobe |
| ld_itlb | input | 1 | Load target: 1 instruction buffer, 0 data buffer |
| ld_idx | input | IDX_W | Entry index to load |
| ld_lock | input | 1 | Lock flag of the loaded entry |
| ld_asid | input | ASID_W | Identifier of the loaded entry |
| ld_vtag | input | VTAG_W | Virtual tag of the loaded entry |
| ld_ppage | input | PPAGE_W | Physical page of the loaded entry |
| derr_en | input | 1 | Data-side access fault pulse |
| derr_idx | input | IDX_W | Entry index that caused the fault |
| probe_hit | output | 1 | Result of the last probe |
| probe_ppage | output | PPAGE_W | Page of the entry the last probe hit, 0 on a miss |

## Verification
The assertions check several things on every cycle. A clear-all leaves no valid entry. A clear of unlocked entries leaves no valid unlocked entry. A probe that sees a match reports a hit. A fault pulse with no register write lands in the allocation address. The chosen victim is never a valid locked entry unless all entries are locked. The bench scenarios show the rest: which index wins a hit, how the replacement pointer moves after loads and stays put across probes, the ordering between simultaneous command bits, the way a clear by identifier spares other address spaces and locked entries, and the steering between the two buffers.

// File: rtl/tlb_op_ctrl.sv
module tlb_op_ctrl #(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8,
  parameter int VTAG_W  = 20,
  parameter int PPAGE_W = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [VTAG_W-1:0]  srch_vtag,
  input  logic [ASID_W-1:0]  cur_asid,
  input  logic               ld_en,
  input  logic               ld_itlb,
  input  logic [IDX_W-1:0]   ld_idx,
  input  logic               ld_lock,
  input  logic [ASID_W-1:0]  ld_asid,
  input  logic [VTAG_W-1:0]  ld_vtag,
  input  logic [PPAGE_W-1:0] ld_ppage,
  input  logic               derr_en,
  input  logic [IDX_W-1:0]   derr_idx,
  output logic               probe_hit,
  output logic [PPAGE_W-1:0] probe_ppage
);

  logic [1:0][ENTRIES-1:0] valid_q, lock_q;
  logic [ASID_W-1:0]  asid_q  [2][ENTRIES];
  logic [VTAG_W-1:0]  vtag_q  [2][ENTRIES];
  logic [PPAGE_W-1:0] ppage_q [2][ENTRIES];
  logic [IDX_W-1:0]   ptr_q   [2];
  logic [IDX_W-1:0]   aa_q;
  logic               sel_q;
  logic [2:0]         acc_q;

  logic [1:0][ENTRIES-1:0] hit_vec;
  logic [1:0]              hit_any;
  logic [IDX_W-1:0]        hit_idx [2];
  logic [IDX_W-1:0]        victim  [2];

  wire w_sel   = reg_wdata[4];
  wire do_ca   = reg_we & reg_wdata[7];
  wire do_cnl  = reg_we & reg_wdata[6] & ~reg_wdata[7];
  wire do_cas  = reg_we & reg_wdata[5] & ~|reg_wdata[7:6];
  wire do_srch = reg_we & reg_wdata[8] & ~|reg_wdata[7:5];
  wire do_uaa  = reg_we & reg_wdata[0] & ~|reg_wdata[8:5];

  assign reg_rdata = {{(16-IDX_W){1'b0}}, aa_q, 11'b0, sel_q, acc_q, 1'b0};

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      hit_idx[t] = '0;
      victim[t]  = ptr_q[t];
      for (int i = 0; i < ENTRIES; i++)
        hit_vec[t][i] = valid_q[t][i] && vtag_q[t][i] == srch_vtag && asid_q[t][i] == cur_asid;
      hit_any[t] = |hit_vec[t];
      for (int i = ENTRIES-1; i >= 0; i--)
        if (hit_vec[t][i]) hit_idx[t] = IDX_W'(i);
      for (int k = ENTRIES-1; k >= 0; k--) begin
        logic [IDX_W-1:0] cand;
        cand = ptr_q[t] + IDX_W'(k);
        if (!(valid_q[t][cand] && lock_q[t][cand])) victim[t] = cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
      for (int t = 0; t < 2; t++) begin
        ptr_q[t] <= '0;
        for (int i = 0; i < ENTRIES; i++) begin
          asid_q[t][i]  <= '0;
          vtag_q[t][i]  <= '0;
          ppage_q[t][i] <= '0;
        end
      end
    end else begin
      if (ld_en) begin
        valid_q[ld_itlb][ld_idx] <= 1'b1;
        lock_q[ld_itlb][ld_idx]  <= ld_lock;
        asid_q[ld_itlb][ld_idx]  <= ld_asid;
        vtag_q[ld_itlb][ld_idx]  <= ld_vtag;
        ppage_q[ld_itlb][ld_idx] <= ld_ppage;
        ptr_q[ld_itlb]           <= ld_idx + 1'b1;
      end
      if (do_ca) begin
        valid_q <= '0;
        lock_q  <= '0;
        ptr_q[0] <= '0;
        ptr_q[1] <= '0;
      end else if (do_cnl) begin
        valid_q <= valid_q & lock_q;
      end else if (do_cas) begin
        for (int t = 0; t < 2; t++)
          for (int i = 0; i < ENTRIES; i++)
            if (!lock_q[t][i] && asid_q[t][i] == cur_asid) valid_q[t][i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aa_q        <= '0;
      sel_q       <= 1'b0;
      acc_q       <= '0;
      probe_hit   <= 1'b0;
      probe_ppage <= '0;
    end else begin
      if (reg_we) begin
        sel_q <= w_sel;
        acc_q <= reg_wdata[3:1];
      end
      if (do_srch) begin
        aa_q        <= hit_any[w_sel] ? hit_idx[w_sel] : victim[w_sel];
        probe_hit   <= hit_any[w_sel];
        probe_ppage <= hit_any[w_sel] ? ppage_q[w_sel][hit_idx[w_sel]] : '0;
      end else if (do_uaa) begin
        aa_q <= victim[w_sel];
      end else if (derr_en) begin
        aa_q <= derr_idx;
      end
    end
  end

  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_wdata[7] |=> valid_q == '0);

  a_r9_unlocked_gone: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_wdata[6] && !reg_wdata[7] |=> (valid_q & ~lock_q) == '0);

  a_r3_probe_hit: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_wdata[8] && !reg_wdata[7] && !reg_wdata[6] && !reg_wdata[5] && hit_any[reg_wdata[4]]
    |=> probe_hit);

  a_r7_fault_index: assert property (@(posedge clk) disable iff (!rst_n)
    derr_en && !reg_we |=> aa_q == $past(derr_idx));

  a_r5_victim_d: assert property (@(posedge clk) disable iff (!rst_n)
    !(&(valid_q[0] & lock_q[0])) |-> !(valid_q[0][victim[0]] && lock_q[0][victim[0]]));

  a_r5_victim_i: assert property (@(posedge clk) disable iff (!rst_n)
    !(&(valid_q[1] & lock_q[1])) |-> !(valid_q[1][victim[1]] && lock_q[1][victim[1]]));

endmodule

// File: tb/tb_tlb_op_ctrl.sv
`timescale 1ns/1ps
module tb_tlb_op_ctrl;
  localparam int IDX_W = 3;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [19:0] srch_vtag = 0;
  logic [7:0]  cur_asid = 0;
  logic        ld_en = 0, ld_itlb = 0, ld_lock = 0;
  logic [2:0]  ld_idx = 0;
  logic [7:0]  ld_asid = 0;
  logic [19:0] ld_vtag = 0, ld_ppage = 0;
  logic        derr_en = 0;
  logic [2:0]  derr_idx = 0;
  logic        probe_hit;
  logic [19:0] probe_ppage;

  tlb_op_ctrl dut (.*);

  always #4 clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic        hit;
    logic [19:0] pp;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (reg_rdata !== e.rd || probe_hit !== e.hit || probe_ppage !== e.pp) begin
        errors++;
        $display("FAIL %s: rdata=%h hit=%b ppage=%h expected rdata=%h hit=%b ppage=%h",
                 e.tag, reg_rdata, probe_hit, probe_ppage, e.rd, e.hit, e.pp);
      end
    end
  end

  task automatic expect_now(string tag, logic [31:0] rd, logic hit, logic [19:0] pp);
    exp_t e;
    e.tag = tag; e.rd = rd; e.hit = hit; e.pp = pp;
    q.push_back(e);
  endtask

  task automatic wr(logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0; reg_wdata = 0;
  endtask

  task automatic load(logic it, logic [2:0] idx, logic lk, logic [7:0] a,
                      logic [19:0] vt, logic [19:0] pp);
    @(posedge clk); #1;
    ld_en = 1; ld_itlb = it; ld_idx = idx; ld_lock = lk;
    ld_asid = a; ld_vtag = vt; ld_ppage = pp;
    @(posedge clk); #1;
    ld_en = 0;
  endtask

  task automatic probe(logic [19:0] vt, logic [7:0] a, logic [31:0] d);
    srch_vtag = vt; cur_asid = a;
    wr(d);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    expect_now("R1 reset state", 32'h0, 1'b0, 20'h0);

    load(0, 3'd0, 0, 8'd1, 20'h100, 20'hA0);
    load(0, 3'd1, 1, 8'd2, 20'h101, 20'hA1);
    load(0, 3'd2, 0, 8'd1, 20'h102, 20'hA2);

    probe(20'h101, 8'd2, 32'h100);
    expect_now("R3 R2 probe hit, command bit reads 0", 32'h0001_0000, 1'b1, 20'hA1);
    probe(20'h200, 8'd1, 32'h100);
    expect_now("R4 probe miss gives victim", 32'h0003_0000, 1'b0, 20'h0);
    wr(32'h001);
    expect_now("R6 R5 alloc query, probe left pointer", 32'h0003_0000, 1'b0, 20'h0);

    load(1, 3'd0, 1, 8'd1, 20'h300, 20'hB0);
    load(1, 3'd7, 1, 8'd1, 20'h307, 20'hB7);
    wr(32'h011);
    expect_now("R11 R5 instruction buffer skips locked", 32'h0001_0010, 1'b0, 20'h0);
    wr(32'hFFFF_001E);
    expect_now("R2 access bits stored, alloc field ignores writes", 32'h0001_001E, 1'b0, 20'h0);

    @(posedge clk); #1;
    derr_en = 1; derr_idx = 3'd5;
    @(posedge clk); #1;
    derr_en = 0;
    expect_now("R7 fault index loaded", 32'h0005_001E, 1'b0, 20'h0);

    load(0, 3'd4, 0, 8'd3, 20'h104, 20'hA4);
    cur_asid = 8'd1;
    wr(32'h020);
    expect_now("R10 clear by identifier reads back 0", 32'h0005_0000, 1'b0, 20'h0);
    probe(20'h100, 8'd1, 32'h100);
    expect_now("R10 matching unlocked entry gone", 32'h0005_0000, 1'b0, 20'h0);
    probe(20'h104, 8'd3, 32'h100);
    expect_now("R10 other identifier kept", 32'h0004_0000, 1'b1, 20'hA4);
    probe(20'h101, 8'd2, 32'h100);
    expect_now("R10 locked entry kept", 32'h0001_0000, 1'b1, 20'hA1);

    wr(32'h040);
    expect_now("R9 clear unlocked leaves probe state", 32'h0001_0000, 1'b1, 20'hA1);
    probe(20'h104, 8'd3, 32'h100);
    expect_now("R9 unlocked entry gone", 32'h0005_0000, 1'b0, 20'h0);
    probe(20'h101, 8'd2, 32'h100);
    expect_now("R9 locked entry survives", 32'h0001_0000, 1'b1, 20'hA1);

    probe(20'h200, 8'd1, 32'h1E0);
    expect_now("R12 clear-all outranks probe", 32'h0001_0000, 1'b1, 20'hA1);
    probe(20'h101, 8'd2, 32'h100);
    expect_now("R8 locked data entry cleared, pointer 0", 32'h0000_0000, 1'b0, 20'h0);
    probe(20'h300, 8'd1, 32'h110);
    expect_now("R8 instruction buffer cleared", 32'h0000_0010, 1'b0, 20'h0);

    load(0, 3'd6, 0, 8'd1, 20'h106, 20'hA6);
    probe(20'h106, 8'd1, 32'h101);
    expect_now("R12 probe outranks alloc query", 32'h0006_0000, 1'b1, 20'hA6);
    wr(32'h001);
    expect_now("R5 load moved pointer", 32'h0007_0000, 1'b1, 20'hA6);

    wait (q.size() == 0);
    @(posedge clk); #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule